// File: doc/BRIEF.md
# Peripheral Interrupt Controller with Timer Prescale

This block gathers interrupt requests from ten fixed peripheral sources into a sticky status register and combines them into one interrupt line for the processor. A register port lets software set a mask register, read the status and clear it bit by bit, set up a timer prescaler and hold a timer setting. The mask register has three parts. The lowest bit turns interrupt delivery on or off for the whole block. The next bit chooses how the line signals: a level that follows the pending state, or a one-cycle pulse when the pending state appears. The six bits above that each enable one group of sources.

The prescaler is a free-running divider with an enable bit. It emits a one-cycle tick every 2^N clock cycles, where N is the 4-bit prescale value. Writes to the prescale value saturate at 14. The timer-set register is storage that software can read back. Reads return data one clock after the address is presented. Every output of the block comes from a register.

Top module: `pic_top`

## Requirements
- R1: After the synchronous active-high reset, all registers read 0, and `irq_o`, `tick_o` and `rd_data_o` are 0.
- R2: Status bit positions are 0 to 3 for GPIO banks A to D, 4 to 6 for LED0 to LED2, 7 for SPI, 8 for SMBus and 9 for one-wire. A source that is high sets its bit on the next edge. A set bit stays set until a 1 is written to it at offset 0x04. While the source is still high the bit stays set even if that write arrives.
- R3: Offset 0x00 reads the 8-bit mask, 0x04 the 10-bit status, 0x08 the prescaler as {enable at bit 4, value at bits 3:0}, and 0x0C the 16-bit timer setting. `rd_data_o` shows the register at `addr_i` one cycle later. Every other address reads 0, and writes to it change nothing.
- R4: When mask bit 0 (global enable) is 0, `irq_o` stays 0 whatever the status holds.
- R5: Mask bit 2+g set to 1 enables group g. Group 0 is status bits 0 to 3, group 1 is bits 4 to 6, group 2 is bit 7, group 3 is bit 8 and group 4 is bit 9. Mask bit 7 (group 5) has no sources, so it never raises `irq_o`.
- R6: With mask bit 1 at 0 (level mode), `irq_o` in each cycle equals the global enable ANDed with the OR of the enabled status bits, as they stood one cycle earlier.
- R7: With mask bit 1 at 1 (edge mode), `irq_o` is high for exactly one cycle after that gated OR goes from 0 to 1. It is not high again until the OR has fallen and risen once more.
- R8: A prescale value above 14 written to offset 0x08 is stored as 14. Values from 0 to 14 are stored as written.
- R9: While the prescale enable is 1, `tick_o` pulses once every 2^N cycles, where N is the stored value. While the enable is 0, `tick_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | 10 | Interrupt requests from the peripherals, active high |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte address |
| wr_data_i | input | 16 | Register write data |
| rd_data_o | output | 16 | Register read data, one cycle after the address |
| irq_o | output | 1 | Interrupt line to the processor |
| tick_o | output | 1 | Prescaled timer tick |

## Verification
The bench targets a set of corner cases, each with the fault it would expose:
- **Clear racing a held source.** A status clear that overrides a source still high would drop a pending request.
- **Spare mask bit.** If the spare bit were wired to a group, the line would rise with no enabled source.
- **Held source in edge mode.** A pulse generator without a history register would pulse on every cycle.
- **Mode switch while requests are pending.** The history register is tracked in both modes, so the first edge-mode cycle gives no stray pulse.

On the prescaler side, the bench writes the value 15, which must read back as 14. It also counts ticks over a fixed window for several values. An off-by-one divider would produce the wrong count.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NUM_SRC  = 10;
  localparam int NUM_GRP  = 6;
  localparam int MASK_W   = 2 + NUM_GRP;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 5;
  localparam int PSC_W    = 4;
  localparam int PSC_MAX  = 14;
  localparam int TSET_W   = 16;

  localparam logic [ADDR_W-1:0] OFF_MASK = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_STAT = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_PSC  = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_TSET = 5'h0C;

  localparam int GEN_BIT  = 0;
  localparam int EDGE_BIT = 1;
  localparam int GRP_LSB  = 2;

  // group index gating each status bit
  function automatic int grp_of(input int idx);
    if (idx < 4)      return 0;
    else if (idx < 7) return 1;
    else              return idx - 5;
  endfunction
endpackage

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int P_DATA_W  = DATA_W,
  parameter int P_ADDR_W  = ADDR_W,
  parameter int P_NSRC    = NUM_SRC,
  parameter int P_MASK_W  = MASK_W,
  parameter int P_PSC_W   = PSC_W,
  parameter int P_PSC_MAX = PSC_MAX,
  parameter int P_TSET_W  = TSET_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en_i,
  input  logic [P_ADDR_W-1:0] addr_i,
  input  logic [P_DATA_W-1:0] wr_data_i,
  input  logic [P_NSRC-1:0]   status_i,
  output logic [P_MASK_W-1:0] mask_o,
  output logic [P_PSC_W-1:0]  psc_val_o,
  output logic                psc_en_o,
  output logic [P_NSRC-1:0]   clr_o,
  output logic [P_DATA_W-1:0] rd_data_o
);
  localparam logic [P_PSC_W-1:0] SAT = P_PSC_W'(P_PSC_MAX);

  logic [P_MASK_W-1:0] mask_q;
  logic [P_PSC_W-1:0]  psc_q;
  logic                pen_q;
  logic [P_TSET_W-1:0] tset_q;
  logic [P_PSC_W-1:0]  psc_in;
  logic [P_DATA_W-1:0] rd_mux;

  always_comb begin
    psc_in = wr_data_i[P_PSC_W-1:0];
    if (psc_in > SAT) psc_in = SAT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      psc_q  <= '0;
      pen_q  <= 1'b0;
      tset_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        OFF_MASK: mask_q <= wr_data_i[P_MASK_W-1:0];
        OFF_PSC: begin
          psc_q <= psc_in;
          pen_q <= wr_data_i[P_PSC_W];
        end
        OFF_TSET: tset_q <= wr_data_i[P_TSET_W-1:0];
        default: ;
      endcase
    end
  end

  assign clr_o = (wr_en_i && addr_i == OFF_STAT) ? wr_data_i[P_NSRC-1:0] : '0;

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      OFF_MASK: rd_mux[P_MASK_W-1:0] = mask_q;
      OFF_STAT: rd_mux[P_NSRC-1:0]   = status_i;
      OFF_PSC:  rd_mux[P_PSC_W:0]    = {pen_q, psc_q};
      OFF_TSET: rd_mux[P_TSET_W-1:0] = tset_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= rd_mux;
  end

  assign mask_o    = mask_q;
  assign psc_val_o = psc_q;
  assign psc_en_o  = pen_q;
endmodule

// File: rtl/pic_status.sv
module pic_status #(
  parameter int P_NSRC = pic_pkg::NUM_SRC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [P_NSRC-1:0] src_i,
  input  logic [P_NSRC-1:0] clr_i,
  output logic [P_NSRC-1:0] status_o
);
  // a live request wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) status_o <= '0;
    else     status_o <= (status_o & ~clr_i) | src_i;
  end
endmodule

// File: rtl/pic_irq_out.sv
module pic_irq_out
  import pic_pkg::*;
#(
  parameter int P_NSRC   = NUM_SRC,
  parameter int P_MASK_W = MASK_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [P_NSRC-1:0]   status_i,
  input  logic [P_MASK_W-1:0] mask_i,
  output logic                irq_o
);
  logic [P_NSRC-1:0] src_en;
  logic              any_req;
  logic              any_d;

  for (genvar i = 0; i < P_NSRC; i++) begin : g_gate
    localparam int G = grp_of(i);
    assign src_en[i] = mask_i[GRP_LSB + G];
  end

  assign any_req = mask_i[GEN_BIT] & (|(status_i & src_en));

  always_ff @(posedge clk) begin
    if (rst) begin
      any_d <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      any_d <= any_req;
      irq_o <= mask_i[EDGE_BIT] ? (any_req & ~any_d) : any_req;
    end
  end
endmodule

// File: rtl/pic_prescale.sv
module pic_prescale #(
  parameter int P_PSC_W   = pic_pkg::PSC_W,
  parameter int P_PSC_MAX = pic_pkg::PSC_MAX
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic [P_PSC_W-1:0] val_i,
  output logic               tick_o
);
  localparam int CNT_W = (P_PSC_MAX < 1) ? 1 : P_PSC_MAX;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] low_mask;

  always_comb begin
    for (int k = 0; k < CNT_W; k++)
      low_mask[k] = (k < int'(val_i));
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= ((cnt_q & low_mask) == low_mask);
    end
  end
endmodule

// File: rtl/pic_top.sv
module pic_top
  import pic_pkg::*;
#(
  parameter int P_DATA_W  = DATA_W,
  parameter int P_ADDR_W  = ADDR_W,
  parameter int P_PSC_W   = PSC_W,
  parameter int P_PSC_MAX = PSC_MAX,
  parameter int P_TSET_W  = TSET_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic                wr_en_i,
  input  logic [P_ADDR_W-1:0] addr_i,
  input  logic [P_DATA_W-1:0] wr_data_i,
  output logic [P_DATA_W-1:0] rd_data_o,
  output logic                irq_o,
  output logic                tick_o
);
  logic [MASK_W-1:0]  mask_q;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] clr_w;
  logic [P_PSC_W-1:0] psc_val;
  logic               psc_en;

  pic_regs #(
    .P_DATA_W(P_DATA_W), .P_ADDR_W(P_ADDR_W), .P_NSRC(NUM_SRC),
    .P_MASK_W(MASK_W), .P_PSC_W(P_PSC_W), .P_PSC_MAX(P_PSC_MAX),
    .P_TSET_W(P_TSET_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wr_data_i(wr_data_i), .status_i(status_q), .mask_o(mask_q),
    .psc_val_o(psc_val), .psc_en_o(psc_en), .clr_o(clr_w),
    .rd_data_o(rd_data_o)
  );

  pic_status #(.P_NSRC(NUM_SRC)) u_status (
    .clk(clk), .rst(rst), .src_i(src_i), .clr_i(clr_w), .status_o(status_q)
  );

  pic_irq_out #(.P_NSRC(NUM_SRC), .P_MASK_W(MASK_W)) u_irq (
    .clk(clk), .rst(rst), .status_i(status_q), .mask_i(mask_q), .irq_o(irq_o)
  );

  pic_prescale #(.P_PSC_W(P_PSC_W), .P_PSC_MAX(P_PSC_MAX)) u_psc (
    .clk(clk), .rst(rst), .en_i(psc_en), .val_i(psc_val), .tick_o(tick_o)
  );
endmodule

// File: rtl/pic_chk.sv
module pic_chk
  import pic_pkg::*;
#(
  parameter int P_ADDR_W  = ADDR_W,
  parameter int P_PSC_W   = PSC_W,
  parameter int P_PSC_MAX = PSC_MAX
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en_i,
  input logic [P_ADDR_W-1:0] addr_i,
  input logic [NUM_SRC-1:0]  src_i,
  input logic [MASK_W-1:0]   mask_q,
  input logic [NUM_SRC-1:0]  status_q,
  input logic [P_PSC_W-1:0]  psc_val,
  input logic                psc_en,
  input logic                irq_o,
  input logic                tick_o
);
  logic stat_wr;
  assign stat_wr = wr_en_i && (addr_i == OFF_STAT);

  // R2
  src_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & $past(src_i)) == $past(src_i)));

  // R2
  status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !stat_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R4
  gen_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !mask_q[GEN_BIT] |=> !irq_o);

  // R7
  edge_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q[EDGE_BIT] && irq_o && $past(mask_q[EDGE_BIT])) |=> !irq_o);

  // R8
  psc_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    int'(psc_val) <= P_PSC_MAX);

  // R9
  tick_off_chk: assert property (@(posedge clk) disable iff (rst)
    !psc_en |=> !tick_o);
endmodule

bind pic_top pic_chk #(
  .P_ADDR_W(P_ADDR_W), .P_PSC_W(P_PSC_W), .P_PSC_MAX(P_PSC_MAX)
) u_chk (
  .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .addr_i(addr_i), .src_i(src_i),
  .mask_q(mask_q), .status_q(status_q), .psc_val(psc_val), .psc_en(psc_en),
  .irq_o(irq_o), .tick_o(tick_o)
);

// File: tb/tb_pic_top.sv
`timescale 1ns/1ps
module tb_pic_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  src_i = '0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic        irq_o, tick_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pic_top dut (
    .clk(clk), .rst(rst), .src_i(src_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o), .tick_o(tick_o)
  );

  // reference state computed from the requirements
  logic [7:0]  m_mask;
  logic [9:0]  m_stat;
  logic [3:0]  m_psc;
  logic        m_pen, m_anyd, m_irq, m_tick_ok;
  logic [15:0] m_tset, m_rd;

  function automatic int grp(input int i);
    if (i <= 3) return 0;
    if (i <= 6) return 1;
    if (i == 7) return 2;
    if (i == 8) return 3;
    return 4;
  endfunction

  function automatic logic [15:0] rd_ref(input logic [4:0] a);
    case (a)
      5'h00: return {8'h0, m_mask};
      5'h04: return {6'h0, m_stat};
      5'h08: return {11'h0, m_pen, m_psc};
      5'h0C: return m_tset;
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mask = '0; m_stat = '0; m_psc = '0; m_pen = 0; m_anyd = 0;
      m_irq = 0; m_tick_ok = 0; m_tset = '0; m_rd = '0;
    end else begin
      logic [9:0] en;
      logic any;
      for (int i = 0; i < 10; i++) en[i] = m_mask[2 + grp(i)];
      any = m_mask[0] && |(m_stat & en);
      m_irq = m_mask[1] ? (any && !m_anyd) : any;
      m_anyd = any;
      m_tick_ok = m_pen;
      m_rd = rd_ref(addr_i);
      if (wr_en_i && addr_i == 5'h04) m_stat = m_stat & ~wr_data_i[9:0];
      m_stat = m_stat | src_i;
      if (wr_en_i) begin
        case (addr_i)
          5'h00: m_mask = wr_data_i[7:0];
          5'h08: begin
            m_psc = (wr_data_i[3:0] > 4'd14) ? 4'd14 : wr_data_i[3:0];
            m_pen = wr_data_i[4];
          end
          5'h0C: m_tset = wr_data_i;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  bit model_on = 0;
  always @(negedge clk) begin
    cyc++;
    if (model_on && !rst) begin
      check(irq_o === m_irq, "R4 R5 R6 R7 irq_o", irq_o, m_irq);
      check(rd_data_o === m_rd, "R2 R3 rd_data_o", rd_data_o, m_rd);
      if (!m_tick_ok) check(tick_o === 1'b0, "R9 tick while off", tick_o, 0);
    end
    if (cyc > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en_i = 1; addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    addr_i = a;
    @(negedge clk);
    d = rd_data_o;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v;
    int ticks, pulses;
    void'($urandom(32'h5eed_1234));
    idle(4);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(irq_o === 0, "R1 irq after reset", irq_o, 0);
    check(tick_o === 0, "R1 tick after reset", tick_o, 0);
    check(rd_data_o === 0, "R1 rdata after reset", rd_data_o, 0);
    for (int a = 0; a < 16; a += 4) begin
      rd(5'(a), v);
      check(v === 0, "R1 register reset value", v, 0);
    end
    model_on = 1;

    // R3 readback and unmapped address
    wr(5'h0C, 16'hBEEF);
    rd(5'h0C, v); check(v === 16'hBEEF, "R3 timer set readback", v, 16'hBEEF);
    wr(5'h10, 16'hFFFF);
    rd(5'h10, v); check(v === 0, "R3 unmapped reads 0", v, 0);
    rd(5'h00, v); check(v === 0, "R3 unmapped write ignored", v, 0);

    // R5 spare mask bit raises nothing
    wr(5'h00, 16'h0081);
    @(negedge clk); src_i = 10'h3FF; @(negedge clk); src_i = 0;
    idle(3);
    check(irq_o === 0, "R5 spare mask bit", irq_o, 0);
    rd(5'h04, v); check(v === 16'h03FF, "R2 all sources captured", v, 16'h03FF);
    // R4 groups enabled but global off
    wr(5'h00, 16'h00FC);
    idle(3);
    check(irq_o === 0, "R4 global enable off", irq_o, 0);
    wr(5'h04, 16'h03FF);
    rd(5'h04, v); check(v === 0, "R2 write-one clear", v, 0);

    // R2 clear while source held high
    @(negedge clk); src_i = 10'h080;
    wr(5'h04, 16'h0080);
    rd(5'h04, v); check(v === 16'h0080, "R2 held source beats clear", v, 16'h0080);
    src_i = 0;
    wr(5'h04, 16'h03FF);

    // R7 edge mode with a held source: one pulse
    wr(5'h00, 16'h00FF);
    pulses = 0;
    @(negedge clk); src_i = 10'h100;
    repeat (12) begin @(negedge clk); if (irq_o) pulses++; end
    check(pulses == 1, "R7 single pulse on held request", pulses, 1);
    src_i = 0;
    wr(5'h04, 16'h03FF);
    idle(2);
    pulses = 0;
    @(negedge clk); src_i = 10'h001;
    repeat (6) begin @(negedge clk); if (irq_o) pulses++; end
    check(pulses == 1, "R7 second rise gives new pulse", pulses, 1);
    src_i = 0;
    // R6 switch to level with request pending
    wr(5'h00, 16'h00FD);
    idle(2);
    check(irq_o === 1, "R6 level follows pending", irq_o, 1);
    wr(5'h04, 16'h03FF);
    idle(2);
    check(irq_o === 0, "R6 level drops after clear", irq_o, 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      src_i = ($urandom % 5 == 0) ? 10'($urandom) : 10'h0;
      wr_en_i = ($urandom % 4 == 0);
      case ($urandom % 5)
        0: addr_i = 5'h00;
        1: addr_i = 5'h04;
        2: addr_i = 5'h0C;
        3: addr_i = 5'h10;
        default: addr_i = 5'($urandom);
      endcase
      if (wr_en_i && addr_i == 5'h08) addr_i = 5'h04;
      wr_data_i = 16'($urandom);
    end
    @(negedge clk); wr_en_i = 0; src_i = 0;

    // R8 saturation
    wr(5'h08, 16'h000F);
    rd(5'h08, v); check(v === 16'h000E, "R8 value 15 saturates", v, 16'h000E);
    wr(5'h08, 16'h000D);
    rd(5'h08, v); check(v === 16'h000D, "R8 value 13 kept", v, 16'h000D);

    // R9 tick rate
    for (int p = 0; p < 4; p++) begin
      wr(5'h08, 16'h0010 | 16'(p));
      idle(20);
      ticks = 0;
      repeat (128) begin @(negedge clk); if (tick_o) ticks++; end
      check(ticks == (128 >> p), "R9 tick count", ticks, 128 >> p);
    end
    wr(5'h08, 16'h0000);
    idle(2);
    ticks = 0;
    repeat (64) begin @(negedge clk); if (tick_o) ticks++; end
    check(ticks == 0, "R9 disabled no tick", ticks, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule